// File: doc/BRIEF.md
# Elliptic-Curve Ladder Sequencer

This block is the control sequencer of a point multiplier over a 571-bit binary field that uses the Montgomery ladder. It holds no field arithmetic of its own. It receives the base point coordinates, the curve constant and the scalar one byte per cycle and steers them into external buffers. It then drives the register-file addresses, the operand selects and the write-back selects of the arithmetic datapath through four fixed-length phases: affine-to-projective setup, one ladder step per scalar bit, conversion back to affine coordinates with two inversions, and byte-serial output of the result.

Every phase has a fixed cycle budget, so the latency of a multiplication is a constant. From the cycle that accepts `start` until `done` rises, a multiplication takes 5 + 14·(M−1) + 1194 + 2·⌈M/8⌉ cycles, which is 9323 cycles for M = 571. The scalar is scanned from bit M−2 down to bit 0, because its leading bit is assumed to be set. The scalar bit selects which of the two accumulator pairs receives the addition and which receives the doubling. It does so by exchanging their register-file addresses, so one instruction table serves both branches.

Top module: `ecpm_seq`

## Requirements
- R1: After reset, `done`, `dout_vld`, `prm_we`, `key_we` and `rf_we` are all low.
- R2: A `load_prm` pulse sampled while idle starts 3·NB cycles (NB = ⌈M/8⌉ = 72) with `prm_we` high. During these cycles `prm_wsel` steps 0 (x), 1 (y), 2 (b), each value held for NB consecutive cycles. `byte_idx` counts 0 to NB−1 within each value, least significant byte first, and `ld_data` carries `din`.
- R3: On byte NB−1 of any load, only the low M−8·(NB−1) = 3 bits of `din` reach `ld_data`. Its upper bits are zero.
- R4: A `load_key` pulse sampled while idle, with no `load_prm` in the same cycle, starts NB cycles with `key_we` high, `prm_we` low and `byte_idx` counting 0 to NB−1.
- R5: `start` is accepted only while idle, and only once both a parameter load and a key load have completed. A `start` that is not accepted, and any `load_prm`, `load_key` or `start` during a multiplication, changes nothing: no register-file write occurs and no load begins.
- R6: The 5 cycles after an accepted `start` write the register file in this order: 0 (X1), 1 (Z1), 3 (Z2), 4 (T1), 2 (X2).
- R7: During the ladder, `key_idx` starts at M−2 and falls by one every 14 cycles down to 0. Each of those cycles writes the register file.
- R8: When the scalar bit is 1, the 14 writes of a ladder step go to 4,5,1,1,4,5,0,4,5,3,4,5,5,2. When the bit is 0, each of these addresses below 4 is XORed with 2, and addresses 4 and above are unchanged.
- R9: Reconversion lasts 1194 cycles. It has two inversion windows of 583 cycles each, with `wb_sel` = 3 throughout. In each window `rf_we` is high only in the last cycle, and that write goes to address 6 (T3).
- R10: Output lasts 2·NB cycles and reads address 0 (x) and then address 2 (y), least significant byte first. `dout` is `res_byte` registered one cycle, with `dout_vld` high, and the top byte is masked to 3 bits as in R3.
- R11: `done` rises exactly 5 + 14·(M−1) + 1194 + 2·NB cycles after the `start` sampling edge. It then stays high, including through reloads, until the edge that accepts the next `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_prm | input | 1 | Start loading x, y and b |
| load_key | input | 1 | Start loading the scalar |
| start | input | 1 | Start a point multiplication |
| din | input | 8 | Load byte |
| key_bit | input | 1 | Scalar bit at `key_idx` |
| res_byte | input | 8 | Byte `byte_idx` of register `rd_a` |
| dout | output | 8 | Result byte |
| dout_vld | output | 1 | `dout` holds a result byte |
| done | output | 1 | Multiplication finished |
| byte_idx | output | 7 | Byte position for loading and output |
| ld_data | output | 8 | Masked load byte to the buffers |
| prm_we | output | 1 | Parameter buffer write |
| prm_wsel | output | 2 | Parameter buffer written: 0 x, 1 y, 2 b |
| key_we | output | 1 | Key register write |
| key_idx | output | 10 | Scalar bit being scanned |
| rd_a | output | 3 | Register-file read address A |
| rd_b | output | 3 | Register-file read address B |
| wr_addr | output | 3 | Register-file write address |
| rf_we | output | 1 | Register-file write enable |
| opa_sel | output | 2 | Operand A: 0 RF, 1 parameter, 2 one, 3 zero |
| opb_sel | output | 2 | Operand B, same coding |
| wb_sel | output | 2 | Result source: 0 add, 1 multiply, 2 square, 3 inverter |
| prm_rsel | output | 2 | Parameter read: 0 x, 1 y, 2 b |

## Verification
The assertions rely on the datapath answering combinationally. `key_bit` must follow `key_idx`, and `res_byte` must follow `rd_a` and `byte_idx` within the same cycle, so that a registered `dout` always matches the previous cycle's inputs. They also rely on `start`, `load_prm` and `load_key` being single-cycle pulses. The bench meets these conditions with a behavioural key register indexed by `key_idx` and a result model that is a fixed function of the read address and byte index. It pulses the controls only on falling edges, and it deliberately pulses them in mid-multiplication to show that they are ignored.

// File: rtl/ecpm_seq.sv
module ecpm_seq #(
  parameter int M       = 571,
  parameter int W       = 8,
  parameter int INIT_N  = 5,
  parameter int INV_CYC = 583
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_prm,
  input  logic                       load_key,
  input  logic                       start,
  input  logic [W-1:0]               din,
  input  logic                       key_bit,
  input  logic [W-1:0]               res_byte,
  output logic [W-1:0]               dout,
  output logic                       dout_vld,
  output logic                       done,
  output logic [$clog2((M+W-1)/W)-1:0] byte_idx,
  output logic [W-1:0]               ld_data,
  output logic                       prm_we,
  output logic [1:0]                 prm_wsel,
  output logic                       key_we,
  output logic [$clog2(M)-1:0]       key_idx,
  output logic [2:0]                 rd_a,
  output logic [2:0]                 rd_b,
  output logic [2:0]                 wr_addr,
  output logic                       rf_we,
  output logic [1:0]                 opa_sel,
  output logic [1:0]                 opb_sel,
  output logic [1:0]                 wb_sel,
  output logic [1:0]                 prm_rsel
);
  localparam int NB    = (M + W - 1) / W;
  localparam int BW    = $clog2(NB);
  localparam int KW    = $clog2(M);
  localparam int CW    = $clog2(INV_CYC + 1);
  localparam int LASTV = M - (NB - 1) * W;
  localparam logic [W-1:0] TOPM = W'((1 << LASTV) - 1);

  localparam logic [1:0] ADD = 2'd0, MUL = 2'd1, SQR = 2'd2, INV = 2'd3;
  localparam logic [1:0] RF = 2'd0, PRM = 2'd1, ONE = 2'd2, ZRO = 2'd3;
  localparam logic [1:0] PX = 2'd0, PY = 2'd1, PB = 2'd2;
  localparam logic [2:0] X1 = 3'd0, Z1 = 3'd1, X2 = 3'd2, Z2 = 3'd3,
                         T1 = 3'd4, T2 = 3'd5, T3 = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_LDP, S_LDK, S_INIT, S_LAD, S_INV1, S_MID, S_INV2, S_FIN, S_OUT
  } st_t;

  st_t           st_q;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bcnt;
  logic [1:0]    sel;
  logic [KW-1:0] kidx;
  logic          p_ok, k_ok;
  logic [17:0]   opw;
  logic [2:0]    ra0, rb0, wa0;
  logic          byte_last, swap;

  function automatic logic [17:0] mk(input logic we, input logic [1:0] wb,
      input logic [1:0] a, input logic [1:0] b, input logic [2:0] ra,
      input logic [2:0] rb, input logic [2:0] wa, input logic [1:0] ps);
    return {we, wb, a, b, ra, rb, wa, ps};
  endfunction

  function automatic logic [2:0] xch(input logic [2:0] r, input logic s);
    return (s && !r[2]) ? (r ^ 3'b010) : r;
  endfunction

  assign byte_last = bcnt == BW'(NB - 1);
  assign swap      = (st_q == S_LAD) && !key_bit;
  assign byte_idx  = bcnt;
  assign key_idx   = kidx;
  assign prm_we    = st_q == S_LDP;
  assign key_we    = st_q == S_LDK;
  assign prm_wsel  = sel;
  assign ld_data   = byte_last ? (din & TOPM) : din;

  always_comb begin
    opw = '0;
    case (st_q)
      S_INIT: case (cnt)
        CW'(0):  opw = mk(1'b1, ADD, PRM, ZRO, X1, X1, X1, PX);
        CW'(1):  opw = mk(1'b1, ADD, ONE, ZRO, X1, X1, Z1, PX);
        CW'(2):  opw = mk(1'b1, SQR, PRM, ZRO, X1, X1, Z2, PX);
        CW'(3):  opw = mk(1'b1, SQR, RF,  ZRO, Z2, X1, T1, PX);
        default: opw = mk(1'b1, ADD, RF,  PRM, T1, X1, X2, PB);
      endcase
      S_LAD: case (cnt)
        CW'(0):  opw = mk(1'b1, MUL, RF,  RF, X1, Z2, T1, PX);
        CW'(1):  opw = mk(1'b1, MUL, RF,  RF, X2, Z1, T2, PX);
        CW'(2):  opw = mk(1'b1, ADD, RF,  RF, T1, T2, Z1, PX);
        CW'(3):  opw = mk(1'b1, SQR, RF,  RF, Z1, Z1, Z1, PX);
        CW'(4):  opw = mk(1'b1, MUL, RF,  RF, T1, T2, T1, PX);
        CW'(5):  opw = mk(1'b1, MUL, PRM, RF, X1, Z1, T2, PX);
        CW'(6):  opw = mk(1'b1, ADD, RF,  RF, T1, T2, X1, PX);
        CW'(7):  opw = mk(1'b1, SQR, RF,  RF, X2, X2, T1, PX);
        CW'(8):  opw = mk(1'b1, SQR, RF,  RF, Z2, Z2, T2, PX);
        CW'(9):  opw = mk(1'b1, MUL, RF,  RF, T1, T2, Z2, PX);
        CW'(10): opw = mk(1'b1, SQR, RF,  RF, T1, T1, T1, PX);
        CW'(11): opw = mk(1'b1, SQR, RF,  RF, T2, T2, T2, PX);
        CW'(12): opw = mk(1'b1, MUL, PRM, RF, X1, T2, T2, PB);
        default: opw = mk(1'b1, ADD, RF,  RF, T1, T2, X2, PX);
      endcase
      S_INV1, S_INV2:
        opw = mk(cnt == CW'(INV_CYC - 1), INV, RF, ZRO, Z1, X1, T3, PX);
      S_MID: case (cnt)
        CW'(0):  opw = mk(1'b1, MUL, PRM, RF,  X1, Z1, T1, PX);
        CW'(1):  opw = mk(1'b1, ADD, RF,  RF,  T1, X1, T1, PX);
        CW'(2):  opw = mk(1'b1, MUL, PRM, RF,  X1, Z2, T2, PX);
        CW'(3):  opw = mk(1'b1, ADD, RF,  RF,  T2, X2, T2, PX);
        CW'(4):  opw = mk(1'b1, MUL, RF,  RF,  T1, T2, T1, PX);
        CW'(5):  opw = mk(1'b1, MUL, RF,  RF,  Z1, Z2, T2, PX);
        CW'(6):  opw = mk(1'b1, MUL, PRM, RF,  X1, T2, Z1, PX);
        CW'(7):  opw = mk(1'b1, MUL, RF,  RF,  X1, T3, X1, PX);
        CW'(8):  opw = mk(1'b1, SQR, PRM, ZRO, X1, X1, T3, PX);
        CW'(9):  opw = mk(1'b1, ADD, RF,  PRM, T3, X1, T3, PY);
        CW'(10): opw = mk(1'b1, MUL, RF,  RF,  T2, T3, T2, PX);
        CW'(11): opw = mk(1'b1, ADD, RF,  RF,  T1, T2, T1, PX);
        CW'(12): opw = mk(1'b1, ADD, RF,  PRM, X1, X1, T2, PX);
        default: opw = mk(1'b1, MUL, RF,  RF,  T1, T2, T1, PX);
      endcase
      S_FIN: case (cnt)
        CW'(0):  opw = mk(1'b1, MUL, RF, RF,  T1, T3, T1, PX);
        CW'(1):  opw = mk(1'b1, ADD, RF, PRM, T1, X1, X2, PY);
        default: opw = '0;
      endcase
      S_OUT:   opw = mk(1'b0, ADD, RF, RF, sel[0] ? X2 : X1, X1, X1, PX);
      default: opw = '0;
    endcase
  end

  assign {rf_we, wb_sel, opa_sel, opb_sel, ra0, rb0, wa0, prm_rsel} = opw;
  assign rd_a    = xch(ra0, swap);
  assign rd_b    = xch(rb0, swap);
  assign wr_addr = xch(wa0, swap);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE; cnt <= '0; bcnt <= '0; sel <= '0; kidx <= '0;
      p_ok <= 1'b0; k_ok <= 1'b0; done <= 1'b0; dout <= '0; dout_vld <= 1'b0;
    end else begin
      dout_vld <= st_q == S_OUT;
      if (st_q == S_OUT) dout <= byte_last ? (res_byte & TOPM) : res_byte;
      case (st_q)
        S_IDLE:
          if (load_prm) begin st_q <= S_LDP; bcnt <= '0; sel <= '0; end
          else if (load_key) begin st_q <= S_LDK; bcnt <= '0; end
          else if (start && p_ok && k_ok) begin st_q <= S_INIT; cnt <= '0; done <= 1'b0; end
        S_LDP:
          if (byte_last) begin
            bcnt <= '0;
            if (sel == 2'd2) begin st_q <= S_IDLE; p_ok <= 1'b1; end
            else sel <= sel + 2'd1;
          end else bcnt <= bcnt + 1'b1;
        S_LDK:
          if (byte_last) begin bcnt <= '0; st_q <= S_IDLE; k_ok <= 1'b1; end
          else bcnt <= bcnt + 1'b1;
        S_INIT:
          if (cnt == CW'(INIT_N - 1)) begin cnt <= '0; kidx <= KW'(M - 2); st_q <= S_LAD; end
          else cnt <= cnt + 1'b1;
        S_LAD:
          if (cnt == CW'(13)) begin
            cnt <= '0;
            if (kidx == '0) st_q <= S_INV1;
            else kidx <= kidx - 1'b1;
          end else cnt <= cnt + 1'b1;
        S_INV1, S_INV2:
          if (cnt == CW'(INV_CYC - 1)) begin
            cnt <= '0; st_q <= (st_q == S_INV1) ? S_MID : S_FIN;
          end else cnt <= cnt + 1'b1;
        S_MID:
          if (cnt == CW'(13)) begin cnt <= '0; st_q <= S_INV2; end
          else cnt <= cnt + 1'b1;
        S_FIN:
          if (cnt == CW'(13)) begin cnt <= '0; bcnt <= '0; sel <= '0; st_q <= S_OUT; end
          else cnt <= cnt + 1'b1;
        S_OUT:
          if (byte_last) begin
            bcnt <= '0;
            if (sel[0]) begin st_q <= S_IDLE; done <= 1'b1; end
            else sel <= 2'd1;
          end else bcnt <= bcnt + 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecpm_seq_chk.sv
module ecpm_seq_chk #(
  parameter int M = 571,
  parameter int W = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       start,
  input logic [W-1:0]               ld_data,
  input logic                       prm_we,
  input logic                       key_we,
  input logic [$clog2((M+W-1)/W)-1:0] byte_idx,
  input logic [$clog2(M)-1:0]       key_idx,
  input logic                       rf_we,
  input logic [1:0]                 wb_sel,
  input logic [2:0]                 wr_addr,
  input logic [W-1:0]               dout,
  input logic                       dout_vld,
  input logic [W-1:0]               res_byte,
  input logic                       done
);
  localparam int NB    = (M + W - 1) / W;
  localparam int BW    = $clog2(NB);
  localparam int KW    = $clog2(M);
  localparam int LASTV = M - (NB - 1) * W;
  localparam logic [W-1:0] TOPM = W'((1 << LASTV) - 1);

  assert_top_mask_R3: assert property (@(posedge clk) disable iff (rst)
    ((prm_we || key_we) && byte_idx == BW'(NB - 1)) |-> ((ld_data & ~TOPM) == '0));

  assert_no_load_busy_R5: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> !(prm_we || key_we));

  assert_key_walk_R7: assert property (@(posedge clk) disable iff (rst)
    (key_idx != $past(key_idx)) |-> (key_idx == $past(key_idx) - 1'b1 || key_idx == KW'(M - 2)));

  assert_inv_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (wb_sel == 2'd3 && !rf_we) |=> (wb_sel == 2'd3));

  assert_inv_dest_R9: assert property (@(posedge clk) disable iff (rst)
    (wb_sel == 2'd3 && rf_we) |-> (wr_addr == 3'd6));

  assert_dout_reg_R10: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> (dout == (($past(byte_idx) == BW'(NB - 1)) ? ($past(res_byte) & TOPM) : $past(res_byte))));

  assert_done_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(start));

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !rf_we);
endmodule

bind ecpm_seq ecpm_seq_chk #(.M(M), .W(W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .ld_data(ld_data), .prm_we(prm_we),
  .key_we(key_we), .byte_idx(byte_idx), .key_idx(key_idx), .rf_we(rf_we),
  .wb_sel(wb_sel), .wr_addr(wr_addr), .dout(dout), .dout_vld(dout_vld),
  .res_byte(res_byte), .done(done)
);

// File: tb/ecpm_seq_tb_top.sv
module ecpm_seq_tb_top;
  localparam int M  = 571;
  localparam int NB = 72;
  localparam int L0 = 5 + 14 * (M - 1);
  localparam int LR = L0 + 1194;
  localparam int LT = LR + 2 * NB;

  logic clk = 1'b0, rst = 1'b1, load_prm = 1'b0, load_key = 1'b0, start = 1'b0;
  logic [7:0] din = '0;
  logic key_bit;
  logic [7:0] res_byte, dout, ld_data;
  logic dout_vld, done, prm_we, key_we, rf_we;
  logic [6:0] byte_idx;
  logic [1:0] prm_wsel, opa_sel, opb_sel, wb_sel, prm_rsel;
  logic [9:0] key_idx;
  logic [2:0] rd_a, rd_b, wr_addr;
  logic [M-1:0] key_r = '0;
  int ncmp = 0, nbad = 0;

  always #4 clk = ~clk;

  assign key_bit  = (int'(key_idx) < M) ? key_r[key_idx] : 1'b0;
  assign res_byte = {byte_idx[4:0], rd_a} ^ 8'h5A;

  ecpm_seq dut_i (
    .clk(clk), .rst(rst), .load_prm(load_prm), .load_key(load_key), .start(start),
    .din(din), .key_bit(key_bit), .res_byte(res_byte), .dout(dout),
    .dout_vld(dout_vld), .done(done), .byte_idx(byte_idx), .ld_data(ld_data),
    .prm_we(prm_we), .prm_wsel(prm_wsel), .key_we(key_we), .key_idx(key_idx),
    .rd_a(rd_a), .rd_b(rd_b), .wr_addr(wr_addr), .rf_we(rf_we),
    .opa_sel(opa_sel), .opb_sel(opb_sel), .wb_sel(wb_sel), .prm_rsel(prm_rsel)
  );

  task automatic chk(input string req, input int act, input int exp);
    ncmp++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_out(input int ra, input int bi);
    logic [7:0] v;
    v = {bi[4:0], ra[2:0]} ^ 8'h5A;
    if (bi == NB - 1) v = v & 8'h07;
    return int'(v);
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 dout_vld", dout_vld, 0);
    chk("R1 prm_we", prm_we, 0);
    chk("R1 key_we", key_we, 0);
    chk("R1 rf_we", rf_we, 0);
  endtask

  task automatic t_start_blocked(input int exp_done);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      chk("R5 rejected start rf_we", rf_we, 0);
      chk("R5 rejected start done", done, exp_done);
      @(negedge clk);
    end
  endtask

  task automatic t_load_params;
    load_prm = 1'b1;
    @(negedge clk);
    load_prm = 1'b0;
    for (int i = 0; i < 3 * NB; i++) begin
      din = 8'((i * 37 + 11) & 255);
      #1;
      chk("R2 prm_we", prm_we, 1);
      chk("R2 prm_wsel", prm_wsel, i / NB);
      chk("R2 byte_idx", byte_idx, i % NB);
      chk((i % NB == NB - 1) ? "R3 top byte mask" : "R2 ld_data", ld_data,
          (i % NB == NB - 1) ? (din & 8'h07) : din);
      @(negedge clk);
    end
    chk("R2 prm_we after", prm_we, 0);
  endtask

  task automatic t_load_key(input int seed);
    logic [7:0] b;
    load_key = 1'b1;
    @(negedge clk);
    load_key = 1'b0;
    for (int j = 0; j < NB; j++) begin
      b = 8'((j * seed + 5 * seed + 3) & 255);
      if (j < NB - 1) key_r[8*j +: 8] = b;
      else key_r[M-1 -: 3] = b[2:0];
      din = b;
      #1;
      chk("R4 key_we", key_we, 1);
      chk("R4 prm_we", prm_we, 0);
      chk("R4 byte_idx", byte_idx, j);
      chk((j == NB - 1) ? "R3 key top mask" : "R4 ld_data", ld_data,
          (j == NB - 1) ? (b & 8'h07) : b);
      @(negedge clk);
    end
    chk("R4 key_we after", key_we, 0);
  endtask

  task automatic t_run;
    int init_wr[5] = '{0, 1, 3, 4, 2};
    int lad_wr[14] = '{4, 5, 1, 1, 4, 5, 0, 4, 5, 3, 4, 5, 5, 2};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 done cleared by start", done, 0);
    for (int c = 0; c <= LT; c++) begin
      if (c == 300 || c == LR + 10) begin load_prm = 1'b1; load_key = 1'b1; start = 1'b1; end
      else begin load_prm = 1'b0; load_key = 1'b0; start = 1'b0; end
      chk("R5 no load during run", int'(prm_we | key_we), 0);
      if (c < 5) begin
        chk("R6 init we", rf_we, 1);
        chk("R6 init wr_addr", wr_addr, init_wr[c]);
      end else if (c < L0) begin
        int s = (c - 5) / 14;
        int j = (c - 5) % 14;
        int bt = M - 2 - s;
        int e = lad_wr[j];
        if (!key_r[bt] && e < 4) e = e ^ 2;
        chk("R7 key_idx", key_idx, bt);
        chk("R7 ladder we", rf_we, 1);
        chk("R8 ladder wr_addr", wr_addr, e);
      end else if (c < LR) begin
        int r = c - L0;
        int ri = (r < 583) ? r : r - 597;
        if (r < 583 || (r >= 597 && r < 1180)) begin
          chk("R9 inversion wb_sel", wb_sel, 3);
          chk("R9 inversion we", rf_we, (ri == 582) ? 1 : 0);
          if (ri == 582) chk("R9 inversion dest", wr_addr, 6);
        end
      end else if (c < LT) begin
        int o = c - LR;
        chk("R10 byte_idx", byte_idx, o % NB);
        chk("R10 rd_a", rd_a, (o < NB) ? 0 : 2);
      end
      if (c < LT) chk("R11 done low while busy", done, 0);
      if (c <= LR) chk("R10 dout_vld low", dout_vld, 0);
      else begin
        int o = c - LR - 1;
        chk("R10 dout_vld", dout_vld, 1);
        chk("R10 dout", dout, exp_out((o < NB) ? 0 : 2, o % NB));
      end
      if (c == LT) chk("R11 done at fixed latency", done, 1);
      @(negedge clk);
    end
    chk("R10 dout_vld ends", dout_vld, 0);
    for (int i = 0; i < 10; i++) begin
      chk("R11 done holds", done, 1);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    t_reset;
    t_start_blocked(0);
    t_load_params;
    t_start_blocked(0);
    t_load_key(3);
    t_run;
    t_load_key(113);
    chk("R11 done through reload", done, 1);
    t_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule